// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous SRAM with separate read and write data paths. Each address names a group of four data words. One shared address bus carries a read address and a write address in alternating K periods. Data moves on both the K and K# edges, so a burst of four words takes two K periods. The model runs on a single beat clock `clk`. Each rising edge of `clk` stands for one rising edge of K or of K#, and the edges cycle through four beat positions from the first edge after reset.

Read data leaves on its own bus with echo clocks and a valid flag. Write data arrives on its own bus, so the two directions never share wires. A read always returns the newest data for its group. This includes a write whose last word arrives one beat after the read address was taken. In that case the write is forwarded into the pending read buffer as it commits. The data width and the number of groups are parameters.

Top module: `qdr4_sram`

## Requirements
- R1: While `rst_n` is low, `rvalid`=0, `rdata`=0, `cq`=0 and `cqn`=1.
- R2: Edges after reset are numbered beat 0,1,2,3 repeating from the first edge. Beats 0 and 2 are K edges and beats 1 and 3 are K# edges. After each K edge `cq`=1 and `cqn`=0. After each K# edge `cq`=0 and `cqn`=1.
- R3: A read address is taken from `addr` at beat 0 when `rd_sel_n`=0. A write address is taken from the same `addr` bus at beat 2 when `wr_sel_n`=0.
- R4: A write burst takes word 0 from `wdata` at beat 2 (the same edge as its address), then word 1 at beat 3, word 2 at the next beat 0 and word 3 at the next beat 1. The four words are stored as words 0..3 of the addressed group.
- R5: For a read taken at edge E, word 0 of the group appears on `rdata` after edge E+4. Words 1, 2 and 3 follow after edges E+5, E+6 and E+7, in linear order with no wrap variant.
- R6: `rvalid` is 1 exactly during the four beats of each read burst and 0 otherwise. Back-to-back reads give an unbroken run of valid beats.
- R7: While `rvalid` is 0, `rdata` holds its last value.
- R8: With `rd_sel_n`=1 at beat 0, no read burst is produced.
- R9: With `wr_sel_n`=1 at beat 2, the four following write beats are ignored and the array keeps its contents.
- R10: A read returns all writes whose address was taken before the read address. This includes a write taken at the immediately preceding beat 2, whose last word arrives after the read address. A write taken later than the read does not affect it.
- R11: The value of `addr`, `rd_sel_n` and `wr_sel_n` at beats other than their own slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one edge per K or K# rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Shared group address, read at beat 0, write at beat 2 |
| rd_sel_n | input | 1 | Active-low read port select, sampled at beat 0 |
| wr_sel_n | input | 1 | Active-low write port select, sampled at beat 2 |
| wdata | input | W | Write data beat |
| rdata | output | W | Read data beat |
| rvalid | output | 1 | High while a read burst word is driven |
| cq | output | 1 | Echo clock, high after K edges |
| cqn | output | 1 | Complementary echo clock |

## Verification
The hardest case to reach is a read of the group whose write address was taken one beat pair earlier. At that point the array has not yet received the write's final word. The stimulus sets it up by issuing a write in one frame and a read of the same group in the next frame. It also issues a read and a write of one group in the same frame, to show the later write is not forwarded. Throughout, the driver holds both selects active and drives stray addresses on the beats where they must be ignored. The scoreboard times every expected word to its exact edge.

// File: rtl/qdr4_pkg.sv
package qdr4_pkg;
    localparam int BURST = 4;
    typedef logic [1:0] beat_t;
    localparam beat_t RD_SLOT  = 2'd0;
    localparam beat_t COMMIT   = 2'd1;
    localparam beat_t WR_SLOT  = 2'd2;
    localparam beat_t WR_WORD1 = 2'd3;
endpackage

// File: rtl/qdr4_beat_seq.sv
module qdr4_beat_seq
    import qdr4_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output beat_t beat,
    output logic  cq,
    output logic  cqn
);
    typedef struct packed {
        beat_t beat;
        logic  cq;
        logic  cqn;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d      = q;
        d.beat = q.beat + 2'd1;
        // even beats are K edges, odd beats are K# edges
        d.cq   = ~q.beat[0];
        d.cqn  = q.beat[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.beat <= RD_SLOT;
            q.cq   <= 1'b0;
            q.cqn  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign beat = q.beat;
    assign cq   = q.cq;
    assign cqn  = q.cqn;
endmodule

// File: rtl/qdr4_wr_collect.sv
module qdr4_wr_collect
    import qdr4_pkg::*;
#(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  beat_t                   beat,
    input  logic [AW-1:0]           addr,
    input  logic                    wr_sel_n,
    input  logic [W-1:0]            wdata,
    output logic                    commit,
    output logic [AW-1:0]           commit_addr,
    output logic [BURST-1:0][W-1:0] commit_data
);
    typedef struct packed {
        logic                    act;
        logic [AW-1:0]           addr;
        logic [BURST-2:0][W-1:0] wd;
    } wr_t;

    wr_t d, q;

    always_comb begin
        d      = q;
        commit = 1'b0;
        case (beat)
            WR_SLOT: begin
                d.act   = ~wr_sel_n;
                d.addr  = addr;
                d.wd[0] = wdata;
            end
            WR_WORD1: d.wd[1] = wdata;
            RD_SLOT:  d.wd[2] = wdata;
            default: begin
                commit = q.act;
                d.act  = 1'b0;
            end
        endcase
    end

    assign commit_addr = q.addr;
    assign commit_data = {wdata, q.wd};

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/qdr4_rd_path.sv
module qdr4_rd_path
    import qdr4_pkg::*;
#(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  beat_t                   beat,
    input  logic [AW-1:0]           addr,
    input  logic                    rd_sel_n,
    input  logic [BURST-1:0][W-1:0] arr_word,
    input  logic                    commit,
    input  logic [AW-1:0]           commit_addr,
    input  logic [BURST-1:0][W-1:0] commit_data,
    output logic [W-1:0]            rdata,
    output logic                    rvalid
);
    typedef struct packed {
        logic                    pend;
        logic [AW-1:0]           raddr;
        logic [BURST-1:0][W-1:0] rbuf;
        logic [BURST-1:0][W-1:0] obuf;
        logic [W-1:0]            rdata;
        logic                    rvalid;
    } rd_t;

    rd_t d, q;

    always_comb begin
        d = q;
        case (beat)
            RD_SLOT: begin
                // hand the pending burst to the output stage, then take a new read
                d.rvalid = q.pend;
                if (q.pend) begin
                    d.obuf  = q.rbuf;
                    d.rdata = q.rbuf[0];
                end
                d.pend  = ~rd_sel_n;
                d.raddr = addr;
                d.rbuf  = arr_word;
            end
            COMMIT: begin
                if (q.rvalid) d.rdata = q.obuf[1];
                // forward a write that completes after this read was taken
                if (commit && q.pend && commit_addr == q.raddr)
                    d.rbuf = commit_data;
            end
            WR_SLOT:  if (q.rvalid) d.rdata = q.obuf[2];
            default:  if (q.rvalid) d.rdata = q.obuf[3];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;
endmodule

// File: rtl/qdr4_sram.sv
module qdr4_sram
    import qdr4_pkg::*;
#(
    parameter int GROUPS = 16,
    parameter int W      = 8,
    localparam int AW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_sel_n,
    input  logic          wr_sel_n,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          rvalid,
    output logic          cq,
    output logic          cqn
);
    beat_t                   beat;
    logic                    commit;
    logic [AW-1:0]           commit_addr;
    logic [BURST-1:0][W-1:0] commit_data;
    logic [BURST-1:0][W-1:0] arr_word;
    logic [BURST-1:0][W-1:0] mem [GROUPS];

    qdr4_beat_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat),
        .cq    (cq),
        .cqn   (cqn)
    );

    qdr4_wr_collect #(.AW(AW), .W(W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat),
        .addr        (addr),
        .wr_sel_n    (wr_sel_n),
        .wdata       (wdata),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    always_ff @(posedge clk) begin
        if (commit) mem[commit_addr] <= commit_data;
    end

    assign arr_word = mem[addr];

    qdr4_rd_path #(.AW(AW), .W(W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat),
        .addr        (addr),
        .rd_sel_n    (rd_sel_n),
        .arr_word    (arr_word),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .rdata       (rdata),
        .rvalid      (rvalid)
    );
endmodule

// File: rtl/qdr4_sram_chk.sv
module qdr4_sram_chk
    import qdr4_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rd_sel_n,
    input beat_t        beat,
    input logic         rvalid,
    input logic [W-1:0] rdata,
    input logic         cq,
    input logic         cqn
);
    logic       par_q;
    logic [1:0] vcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q  <= 1'b0;
            vcnt_q <= 2'd0;
        end else begin
            par_q <= ~par_q;
            if (rvalid) vcnt_q <= vcnt_q + 2'd1;
        end
    end

    // R2
    cq_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cq == par_q) && (cqn == !par_q));

    // R5
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> (cq && $past(!rd_sel_n && beat == RD_SLOT, 5)));

    // R6
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rvalid) |-> (vcnt_q == 2'd0));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> $stable(rdata));

    // R8
    no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat == RD_SLOT && rd_sel_n) |-> ##5 !rvalid);
endmodule

bind qdr4_sram qdr4_sram_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel_n (rd_sel_n),
    .beat     (beat),
    .rvalid   (rvalid),
    .rdata    (rdata),
    .cq       (cq),
    .cqn      (cqn)
);

// File: tb/sim_qdr4_sram.sv
module sim_qdr4_sram;
    localparam int GROUPS = 16;
    localparam int W      = 8;
    localparam int AW     = $clog2(GROUPS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          rvalid;
    logic          cq;
    logic          cqn;

    always #2 clk = ~clk;

    qdr4_sram #(.GROUPS(GROUPS), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .cq(cq), .cqn(cqn)
    );

    typedef struct {
        logic [W-1:0] word;
        int           at;
        string        tag;
    } exp_t;

    exp_t                    sb[$];
    logic [3:0][W-1:0]       shadow [GROUPS];
    logic [3:0][W-1:0]       pend_w = '0;
    int                      errors = 0;
    int                      checks = 0;
    int                      ecount = 0;
    int                      fidx = 0;
    bit                      running = 0;
    bit                      done = 0;
    logic [W-1:0]            last_rdata = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at edge count %0d",
                     req, what, act, exp, ecount);
        end
    endtask

    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    // monitor: pops the scoreboard as read words appear
    always @(negedge clk) begin
        if (running && ecount > 0) begin
            check(cq == ((ecount - 1) % 2 == 0), "R2", "cq phase", int'(cq),
                  int'((ecount - 1) % 2 == 0));
            check(cqn == !cq, "R2", "cqn complement", int'(cqn), int'(!cq));
            if (rvalid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R6/R8", "unexpected valid beat", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rdata == e.word, e.tag, "read word", int'(rdata), int'(e.word));
                    check(ecount == e.at, "R5", "beat timing", ecount, e.at);
                end
            end else begin
                check(rdata == last_rdata, "R7", "hold while idle", int'(rdata),
                      int'(last_rdata));
                if (sb.size() != 0 && sb[0].at == ecount)
                    check(1'b0, "R6", "missing valid beat", 0, 1);
            end
            last_rdata = rdata;
        end
    end

    function automatic logic [W-1:0] pat(input int g, input int j, input int salt);
        return W'((g * 4 + j) * 7 + salt);
    endfunction

    // driver: one frame = four beats; stray selects/addresses on non-slot beats (R11)
    task automatic frame(input bit rd, input int ra, input bit wr, input int wa,
                         input logic [3:0][W-1:0] wv, input string tag);
        if (rd) begin
            for (int j = 0; j < 4; j++) begin
                exp_t e;
                e.word = shadow[ra][j];
                e.at   = 4 * fidx + 5 + j;
                e.tag  = tag;
                sb.push_back(e);
            end
        end
        addr = AW'(ra); rd_sel_n = !rd; wr_sel_n = 1'b0; wdata = pend_w[2];
        @(negedge clk);
        addr = AW'(ra + 5); rd_sel_n = 1'b0; wr_sel_n = 1'b0; wdata = pend_w[3];
        @(negedge clk);
        addr = AW'(wa); rd_sel_n = 1'b0; wr_sel_n = !wr; wdata = wv[0];
        @(negedge clk);
        addr = AW'(wa + 9); rd_sel_n = 1'b0; wr_sel_n = 1'b1; wdata = wv[1];
        @(negedge clk);
        if (wr) shadow[wa] = wv;
        pend_w = wv;
        fidx++;
    endtask

    function automatic logic [3:0][W-1:0] grp(input int g, input int salt);
        logic [3:0][W-1:0] v;
        for (int j = 0; j < 4; j++) v[j] = pat(g, j, salt);
        return v;
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            check(1'b0, "ALL", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(rvalid == 1'b0, "R1", "rvalid in reset", int'(rvalid), 0);
        check(rdata == '0, "R1", "rdata in reset", int'(rdata), 0);
        check(cq == 1'b0, "R1", "cq in reset", int'(cq), 0);
        check(cqn == 1'b1, "R1", "cqn in reset", int'(cqn), 1);
        rst_n = 1'b1;
        running = 1;
        // fill every group (R4, R3)
        for (int g = 0; g < GROUPS; g++) frame(0, g, 1, g, grp(g, 17), "R4");
        // back-to-back reads of all groups (R5, R6)
        for (int g = 0; g < GROUPS; g++) frame(1, g, 0, 0, grp(g, 99), "R4");
        // write then immediately read same group: forwarding (R10)
        frame(0, 0, 1, 3, grp(3, 51), "R10");
        frame(1, 3, 0, 0, grp(0, 0), "R10");
        // read and write same group in one frame: read sees old data (R10)
        frame(1, 5, 1, 5, grp(5, 77), "R10");
        frame(1, 5, 0, 0, grp(0, 1), "R10");
        // deselected write with data is ignored (R9)
        frame(0, 0, 0, 7, grp(7, 200), "R9");
        frame(1, 7, 0, 0, grp(0, 2), "R9");
        frame(0, 0, 0, 0, grp(0, 3), "R9");
        frame(1, 7, 0, 0, grp(0, 4), "R9");
        // deselected reads only: no output (R8)
        for (int k = 0; k < 3; k++) frame(0, k, 0, 0, grp(k, 5), "R8");
        // interleaved traffic with stray controls (R11)
        for (int k = 0; k < 6; k++) frame(1, (k * 3) % GROUPS, 1, (k * 5 + 1) % GROUPS,
                                         grp(k, 130), "R11");
        frame(1, 6, 0, 0, grp(0, 6), "R11");
        for (int k = 0; k < 3; k++) frame(0, 0, 0, 0, grp(0, 7), "R6");
        check(sb.size() == 0, "R6", "all expected words delivered", sb.size(), 0);
        running = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule